// File: doc/BRIEF.md
# Periodic Frame List Address Generator

This block tracks the host controller's position in the periodic schedule. It keeps a micro-frame index counter and turns that counter into the memory address of the periodic frame list entry that the fetch engine should read next. Software programs a 4 KB-aligned list base and may load the counter while the controller is stopped. Once the run control is set, each micro-frame tick from the timing logic moves the counter forward by one.

The counter's three lowest bits give the micro-frame inside the current frame. The next ten bits select one 32-bit entry of a 1024-entry list, so one entry is reused for eight micro-frames in a row before the pointer moves on. After the last entry the offset wraps back to entry 0, and the list acts as a rolling window. A one-cycle fetch strobe asks the memory side to read a new entry whenever the list offset changes, and once when the controller starts. A rollover pulse marks each change of the counter's top bit, so software can extend the count beyond the hardware width.

Top module: `pflist_addr_gen`

## Requirements
- R1: After reset the counter, micro-frame number, entry address, fetch strobe and rollover pulse are all zero.
- R2: With run high, a tick increments the 14-bit counter by one on the next clock edge, and 0x3FFF steps to 0x0000.
- R3: The micro-frame output always equals counter bits 2:0.
- R4: The entry address is formed from base bits 31:12 in address bits 31:12, counter bits 12:3 in address bits 11:2, and zero in address bits 1:0. Base bits 11:0 written by software are ignored.
- R5: The list offset stays the same for eight consecutive ticks and wraps from 1023 to 0.
- R6: The fetch strobe is high for exactly one cycle following a running tick taken while counter bits 2:0 were 7. Other ticks do not raise it.
- R7: The fetch strobe is high for one cycle following the first cycle in which run is high after being low or after reset.
- R8: While run is low, ticks leave the counter and all outputs unchanged.
- R9: A counter write while run is low loads the value on the next edge. A counter write while run is high is ignored.
- R10: The rollover pulse is high for one cycle following a running tick that changes counter bit 13, and in that cycle the fetch strobe is also high.
- R11: A base write takes effect on the next edge whether run is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run control; the counter advances only while high |
| uframe_tick_i | input | 1 | One-cycle micro-frame tick |
| base_wr_i | input | 1 | Loads the list base |
| base_i | input | 32 | List base value; bits 11:0 are ignored |
| idx_wr_i | input | 1 | Loads the counter (accepted only while halted) |
| idx_i | input | 14 | Counter load value |
| count_o | output | 14 | Current counter value |
| uframe_o | output | 3 | Micro-frame within the current frame |
| entry_addr_o | output | 32 | Address of the frame list entry |
| fetch_o | output | 1 | One-cycle request to fetch a new entry |
| roll_o | output | 1 | One-cycle pulse when counter bit 13 changes |

## Verification
The bench loads the counter just below the bit-13 boundary and runs it through a full lap of the 14-bit range. This covers both rollovers and the wrap of the list offset from 1023 to 0. A design that takes the offset from the wrong bits would move its address every tick instead of every eighth tick. A design that carries wrongly would miss the wrap and not return to entry 0. The bench also checks the start-up strobe, ticks and counter writes while halted, and a counter write attempted while running. Each of these would show up as a stray or missing strobe, or as a counter that moves when it must not.

// File: rtl/pflist_pkg.sv
package pflist_pkg;

    localparam int unsigned PFL_ADDR_W = 32;
    localparam int unsigned PFL_UF_W   = 3;
    localparam int unsigned PFL_OFS_W  = 10;

    typedef enum logic [1:0] {
        FETCH_NONE  = 2'd0,
        FETCH_WRAP  = 2'd1,
        FETCH_START = 2'd2
    } fetch_cause_e;

endpackage

// File: rtl/pflist_index_ctr.sv
module pflist_index_ctr #(
    parameter int unsigned UF_W  = pflist_pkg::PFL_UF_W,
    parameter int unsigned OFS_W = pflist_pkg::PFL_OFS_W,
    localparam int unsigned IDX_W = UF_W + OFS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] wr_val_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             adv_o,
    output logic             uf_carry_o,
    output logic             top_carry_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        adv_o       = run_i && tick_i;
        uf_carry_o  = adv_o && (st_q.idx[UF_W-1:0] == {UF_W{1'b1}});
        top_carry_o = adv_o && (st_q.idx[IDX_W-2:0] == {(IDX_W-1){1'b1}});
        if (adv_o) begin
            st_d.idx = st_q.idx + 1'b1;
        end else if (wr_i && !run_i) begin
            st_d.idx = wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o = st_q.idx;

endmodule

// File: rtl/pflist_event_gen.sv
module pflist_event_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic adv_i,
    input  logic uf_carry_i,
    input  logic top_carry_i,
    output logic fetch_o,
    output logic roll_o
);
    import pflist_pkg::*;

    typedef struct packed {
        logic run;
        logic fetch;
        logic roll;
    } evt_state_t;

    evt_state_t   st_d, st_q;
    fetch_cause_e cause;

    always_comb begin
        if (run_i && !st_q.run) begin
            cause = FETCH_START;
        end else if (adv_i && uf_carry_i) begin
            cause = FETCH_WRAP;
        end else begin
            cause = FETCH_NONE;
        end
        st_d.run   = run_i;
        st_d.fetch = (cause != FETCH_NONE);
        st_d.roll  = top_carry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_o = st_q.fetch;
    assign roll_o  = st_q.roll;

endmodule

// File: rtl/pflist_addr_fmt.sv
module pflist_addr_fmt #(
    parameter int unsigned ADDR_W = pflist_pkg::PFL_ADDR_W,
    parameter int unsigned OFS_W  = pflist_pkg::PFL_OFS_W,
    localparam int unsigned ENTRY_LSB = 2,
    localparam int unsigned BASE_LSB  = OFS_W + ENTRY_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] entry_addr_o
);

    typedef struct packed {
        logic [ADDR_W-BASE_LSB-1:0] base;
    } base_state_t;

    base_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (base_wr_i) begin
            st_d.base = base_i[ADDR_W-1:BASE_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entry_addr_o = {st_q.base, ofs_i, {ENTRY_LSB{1'b0}}};

endmodule

// File: rtl/pflist_addr_gen.sv
module pflist_addr_gen #(
    parameter int unsigned ADDR_W = pflist_pkg::PFL_ADDR_W,
    parameter int unsigned UF_W   = pflist_pkg::PFL_UF_W,
    parameter int unsigned OFS_W  = pflist_pkg::PFL_OFS_W,
    localparam int unsigned IDX_W = UF_W + OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              uframe_tick_i,
    input  logic              base_wr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              idx_wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [IDX_W-1:0]  count_o,
    output logic [UF_W-1:0]   uframe_o,
    output logic [ADDR_W-1:0] entry_addr_o,
    output logic              fetch_o,
    output logic              roll_o
);

    logic adv, uf_carry, top_carry;

    pflist_index_ctr #(
        .UF_W  (UF_W),
        .OFS_W (OFS_W)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .tick_i      (uframe_tick_i),
        .wr_i        (idx_wr_i),
        .wr_val_i    (idx_i),
        .idx_o       (count_o),
        .adv_o       (adv),
        .uf_carry_o  (uf_carry),
        .top_carry_o (top_carry)
    );

    pflist_event_gen u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .adv_i       (adv),
        .uf_carry_i  (uf_carry),
        .top_carry_i (top_carry),
        .fetch_o     (fetch_o),
        .roll_o      (roll_o)
    );

    pflist_addr_fmt #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_wr_i    (base_wr_i),
        .base_i       (base_i),
        .ofs_i        (count_o[UF_W+OFS_W-1:UF_W]),
        .entry_addr_o (entry_addr_o)
    );

    assign uframe_o = count_o[UF_W-1:0];

endmodule

// File: rtl/pflist_addr_gen_chk.sv
module pflist_addr_gen_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned UF_W   = 3,
    parameter int unsigned OFS_W  = 10,
    localparam int unsigned IDX_W = UF_W + OFS_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_i,
    input logic              uframe_tick_i,
    input logic              idx_wr_i,
    input logic [IDX_W-1:0]  idx_i,
    input logic [IDX_W-1:0]  count_o,
    input logic [ADDR_W-1:0] entry_addr_o,
    input logic              fetch_o,
    input logic              roll_o
);

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && uframe_tick_i) |=> (count_o == IDX_W'($past(count_o) + 1'b1))); // R2

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !idx_wr_i) |=> $stable(count_o)); // R8

    AST_HALT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && idx_wr_i) |=> (count_o == $past(idx_i))); // R9

    AST_FETCH_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && uframe_tick_i && (count_o[UF_W-1:0] == {UF_W{1'b1}})) |=> fetch_o); // R6

    AST_FETCH_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |=> fetch_o); // R7

    AST_ROLL_WITH_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        roll_o |-> (fetch_o && (count_o[IDX_W-2:0] == '0))); // R10

    AST_ADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        entry_addr_o[OFS_W+1:2] == count_o[UF_W+OFS_W-1:UF_W]); // R4

endmodule

bind pflist_addr_gen pflist_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .UF_W   (UF_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run_i),
    .uframe_tick_i (uframe_tick_i),
    .idx_wr_i      (idx_wr_i),
    .idx_i         (idx_i),
    .count_o       (count_o),
    .entry_addr_o  (entry_addr_o),
    .fetch_o       (fetch_o),
    .roll_o        (roll_o)
);

// File: tb/pflist_addr_gen_test.sv
`timescale 1ns/1ps
module pflist_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        uframe_tick_i = 1'b0;
    logic        base_wr_i = 1'b0;
    logic [31:0] base_i = '0;
    logic        idx_wr_i = 1'b0;
    logic [13:0] idx_i = '0;
    logic [13:0] count_o;
    logic [2:0]  uframe_o;
    logic [31:0] entry_addr_o;
    logic        fetch_o;
    logic        roll_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [13:0] cnt;
    logic [31:0] base;

    always #2.5 clk = ~clk;

    pflist_addr_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_i),
        .uframe_tick_i (uframe_tick_i),
        .base_wr_i     (base_wr_i),
        .base_i        (base_i),
        .idx_wr_i      (idx_wr_i),
        .idx_i         (idx_i),
        .count_o       (count_o),
        .uframe_o      (uframe_o),
        .entry_addr_o  (entry_addr_o),
        .fetch_o       (fetch_o),
        .roll_o        (roll_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [13:0] c);
        return {b[31:12], c[12:3], 2'b00};
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_state(input string req, input logic f, input logic r);
        chk({req, " count"}, 32'(count_o), 32'(cnt));
        chk({req, " uframe R3"}, 32'(uframe_o), 32'(cnt[2:0]));
        chk({req, " addr R4"}, entry_addr_o, exp_addr(base, cnt));
        chk({req, " fetch"}, 32'(fetch_o), 32'(f));
        chk({req, " roll"}, 32'(roll_o), 32'(r));
    endtask

    initial begin
        #750000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cnt  = '0;
        base = '0;
        cyc();
        cyc();
        // R1: reset state
        chk_state("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc();
        chk_state("R1", 1'b0, 1'b0);

        // R11 / R4: base write while halted, low bits ignored
        base_wr_i = 1'b1; base_i = 32'hABCD_E5A7;
        cyc();
        base_wr_i = 1'b0; base = 32'hABCD_E5A7;
        chk_state("R11", 1'b0, 1'b0);

        // R8: ticks while halted change nothing
        for (int i = 0; i < 3; i++) begin
            uframe_tick_i = 1'b1;
            cyc();
            uframe_tick_i = 1'b0;
            chk_state("R8", 1'b0, 1'b0);
        end

        // R9: load while halted
        idx_wr_i = 1'b1; idx_i = 14'h1FFA;
        cyc();
        idx_wr_i = 1'b0; cnt = 14'h1FFA;
        chk_state("R9", 1'b0, 1'b0);

        // R7: start strobe
        run_i = 1'b1;
        cyc();
        chk_state("R7", 1'b1, 1'b0);
        cyc();
        chk_state("R7 single", 1'b0, 1'b0);

        // R9: load while running is ignored
        idx_wr_i = 1'b1; idx_i = 14'h0005;
        cyc();
        idx_wr_i = 1'b0;
        chk_state("R9 running", 1'b0, 1'b0);

        // R2 R5 R6 R10: full lap of the counter
        for (int i = 0; i < 16384 + 16; i++) begin
            logic f, r;
            f = (cnt[2:0] == 3'd7);
            r = (cnt[12:0] == 13'h1FFF);
            uframe_tick_i = 1'b1;
            cyc();
            uframe_tick_i = 1'b0;
            cnt = cnt + 14'd1;
            chk_state(r ? "R10" : (f ? "R6" : "R2"), f, r);
            if (cnt == 14'h0000) begin
                chk("R5 offset wrap", 32'(entry_addr_o[11:2]), 32'd0);
                chk("R2 counter wrap", 32'(count_o), 32'd0);
            end
            cyc();
            chk_state("R5 idle", 1'b0, 1'b0);
        end

        // R11: base write while running
        base_wr_i = 1'b1; base_i = 32'h1234_5FFF;
        cyc();
        base_wr_i = 1'b0; base = 32'h1234_5FFF;
        chk_state("R11 running", 1'b0, 1'b0);

        // R8: halt again, ticks ignored
        run_i = 1'b0;
        cyc();
        uframe_tick_i = 1'b1;
        cyc();
        uframe_tick_i = 1'b0;
        chk_state("R8 after run", 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule